// File: doc/BRIEF.md
# Clock Multiplier Control Registers

This block is the register front-end of an on-chip clock multiplier loop. Software writes a control value (enable and connect) and a configuration value (multiplier and divider) into holding registers. These values reach the loop only after an unlock pair has been written to a dedicated feed address. The pair is 0xAA followed by 0x55, with no other bus access between the two writes.

The active copies drive the loop's enable, connect, multiplier and divider outputs. A read-only status word reports the active copies together with a synchronized lock indication. The synchronized lock is also presented as an interrupt request.

Reset and power-down both force the loop off and bypassed. Power-down clears only the active enable and connect bits. The holding registers keep their values, so a later feed restores the previous setting.

Top module: `pll_cmr`

## Requirements
- R1: After reset, `pll_en` and `pll_connect` are 0, `pll_mult` is 1, `pll_div` is 2, and reads of the control, configuration and status addresses return 0 while `lock_in` is low.
- R2: Address 0 (control) holds enable in bit 0 and connect in bit 1. Address 1 (configuration) holds the multiplier field in bits 4:0 and the divider field in bits 6:5. Both read back what was written, and all other bits read 0.
- R3: Writing the control or configuration register does not change `pll_en`, `pll_connect`, `pll_mult`, `pll_div` or the status word until a valid feed completes.
- R4: A feed is a write of 0xAA to address 3 followed by a write of 0x55 to address 3. Idle cycles between the two are allowed. Any other bus access between them aborts the sequence: a read of any address, a write to another address, or a write of other data. A valid feed copies the holding registers to the active state, visible in the cycle after the 0x55 write.
- R5: `pll_connect` is 1 only when both the active enable and the active connect bits are 1. Connect alone leaves both outputs at 0.
- R6: While `pwr_down` is high, the active enable and connect bits are cleared from the next cycle on. The holding registers and the active multiplier and divider keep their values.
- R7: `pll_mult` equals the active multiplier field plus one (1 to 32). `pll_div` equals 2 raised to the power (active divider field + 1), giving 2, 4, 8 or 16.
- R8: `lock_in` passes through two flops. `lock_irq` and status bit 10 follow it two clock edges later.
- R9: A read of address 2 (status) returns the active multiplier in bits 4:0, the active divider in 6:5, the active enable in bit 8, the active connect in bit 9 and the synchronized lock in bit 10. All other bits read 0, and writes to this address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down request; clears active enable and connect |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 configuration, 2 status, 3 feed |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| lock_in | input | 1 | Asynchronous lock indication from the loop |
| pll_en | output | 1 | Active enable |
| pll_connect | output | 1 | Active connect, gated by enable |
| pll_mult | output | 6 | Multiplication factor, 1 to 32 |
| pll_div | output | 5 | Division factor, 2 to 16 |
| lock_irq | output | 1 | Synchronized lock interrupt request |

## Verification
A corrupted active register shows up at the drive outputs and in the status word one cycle after the feed that should have loaded it. The sweep compares every multiplier and divider combination at that point. An unlock state that survives an intervening access would show as an unexpected update after the 0x55 write, and this is probed with reads, foreign writes and wrong data. A fault in the lock path or in the power-down clear appears at the outputs within one or two cycles of the input change.

// File: rtl/pll_cmr.sv
module pll_cmr #(
  parameter int MUL_W  = 5,
  parameter int DIV_W  = 2,
  parameter int DATA_W = 16,
  parameter logic [7:0] KEY_A = 8'hAA,
  parameter logic [7:0] KEY_B = 8'h55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_down,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 lock_in,
  output logic                 pll_en,
  output logic                 pll_connect,
  output logic [MUL_W:0]       pll_mult,
  output logic [(1<<DIV_W):0]  pll_div,
  output logic                 lock_irq
);
  localparam int CFG_W  = MUL_W + DIV_W;
  localparam int MO_W   = MUL_W + 1;
  localparam int DO_W   = (1 << DIV_W) + 1;
  localparam logic [1:0] A_CTRL = 2'd0, A_CFG = 2'd1, A_STAT = 2'd2, A_FEED = 2'd3;
  localparam int B_EN = 8, B_CON = 9, B_LOCK = 10;

  logic hold_en, hold_con, act_en, act_con, armed;
  logic [MUL_W-1:0] hold_mul, act_mul;
  logic [DIV_W-1:0] hold_div, act_div;
  logic [1:0] lock_sync;

  wire access  = bus_wr | bus_rd;
  wire feed_wr = bus_wr && bus_addr == A_FEED;
  wire feed_a  = feed_wr && bus_wdata == KEY_A;
  wire feed_ok = armed && feed_wr && bus_wdata == KEY_B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hold_en, hold_con, act_en, act_con, armed} <= '0;
      {hold_mul, act_mul} <= '0;
      {hold_div, act_div} <= '0;
      lock_sync <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) {hold_con, hold_en} <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_CFG)  {hold_div, hold_mul} <= bus_wdata[CFG_W-1:0];
      if (access) armed <= feed_a;
      if (feed_ok) begin
        act_en  <= hold_en;
        act_con <= hold_con;
        act_mul <= hold_mul;
        act_div <= hold_div;
      end
      if (pwr_down) begin
        act_en  <= 1'b0;
        act_con <= 1'b0;
      end
      lock_sync <= {lock_sync[0], lock_in};
    end
  end

  assign pll_en      = act_en;
  assign pll_connect = act_en & act_con;
  assign pll_mult    = MO_W'(act_mul) + MO_W'(1);
  assign pll_div     = DO_W'(2) << act_div;
  assign lock_irq    = lock_sync[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[1:0] = {hold_con, hold_en};
      A_CFG:  bus_rdata[CFG_W-1:0] = {hold_div, hold_mul};
      A_STAT: begin
        bus_rdata[CFG_W-1:0] = {act_div, act_mul};
        bus_rdata[B_EN]   = act_en;
        bus_rdata[B_CON]  = act_con;
        bus_rdata[B_LOCK] = lock_sync[1];
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_HOLD_UNTIL_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> $stable({pll_mult, pll_div})); // R3
  AST_FEED_LOADS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok && !pwr_down) |=> pll_en == $past(hold_en)); // R4
  AST_PWRDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!pll_en && !pll_connect)); // R6
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_in |-> ##2 lock_irq); // R8
  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |-> ##2 !lock_irq); // R8
endmodule

// File: tb/pll_cmr_tb_top.sv
module pll_cmr_tb_top;
  logic clk = 0, rst_n = 0, pwr_down = 0, bus_wr = 0, bus_rd = 0, lock_in = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic pll_en, pll_connect, lock_irq;
  logic [5:0] pll_mult;
  logic [4:0] pll_div;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_cmr dut_i (.clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock_in(lock_in), .pll_en(pll_en), .pll_connect(pll_connect), .pll_mult(pll_mult),
    .pll_div(pll_div), .lock_irq(lock_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic feed();
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [5:0] prev_mult;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 en", pll_en, 0); chk("R1 connect", pll_connect, 0);
    chk("R1 mult", pll_mult, 1); chk("R1 div", pll_div, 2);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 cfg", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    // R2 readback
    wr(0, 8'hFF); rd(0, v); chk("R2 ctrl", v, 16'h3);
    wr(1, 8'hFF); rd(1, v); chk("R2 cfg", v, 16'h7F);
    // R3 no effect before feed
    chk("R3 en", pll_en, 0); chk("R3 mult", pll_mult, 1); chk("R3 div", pll_div, 2);
    wr(2, 8'hFF); rd(2, v); chk("R9 status write ignored", v, 0);
    // R4 aborted feeds
    wr(3, 8'hAA); rd(2, v); wr(3, 8'h55);
    @(negedge clk); chk("R4 abort by read", pll_en, 0);
    wr(3, 8'hAA); wr(0, 8'h03); wr(3, 8'h55);
    @(negedge clk); chk("R4 abort by other write", pll_en, 0);
    wr(3, 8'hAA); wr(3, 8'h12); wr(3, 8'h55);
    @(negedge clk); chk("R4 abort by wrong data", pll_en, 0);
    wr(3, 8'h55); @(negedge clk); chk("R4 lone second key", pll_en, 0);
    // R4 valid feed with idle gap
    wr(3, 8'hAA); repeat (3) @(negedge clk); wr(3, 8'h55);
    chk("R4 en", pll_en, 1); chk("R4 connect", pll_connect, 1);
    chk("R7 mult max", pll_mult, 32); chk("R7 div max", pll_div, 16);
    rd(2, v); chk("R9 status", v, 16'h037F);
    // R5 connect gating
    wr(0, 8'h02); feed();
    chk("R5 con only en", pll_en, 0); chk("R5 con only connect", pll_connect, 0);
    rd(2, v); chk("R5 status con only", v, 16'h027F);
    wr(0, 8'h01); feed();
    chk("R5 en only en", pll_en, 1); chk("R5 en only connect", pll_connect, 0);
    wr(0, 8'h03); feed();
    chk("R5 both", pll_connect, 1);
    // R6 power-down
    @(negedge clk); pwr_down = 1;
    @(negedge clk);
    chk("R6 en cleared", pll_en, 0); chk("R6 connect cleared", pll_connect, 0);
    chk("R6 mult kept", pll_mult, 32);
    rd(0, v); chk("R6 ctrl kept", v, 16'h3);
    rd(2, v); chk("R6 status", v, 16'h007F);
    pwr_down = 0;
    feed(); chk("R6 restored en", pll_en, 1); chk("R6 restored connect", pll_connect, 1);
    // R7 sweep
    prev_mult = pll_mult;
    for (int d = 0; d < 4; d++) begin
      for (int m = 0; m < 32; m++) begin
        wr(1, 8'(d * 32 + m));
        chk("R3 sweep hold", pll_mult, prev_mult);
        feed();
        chk("R7 mult", pll_mult, m + 1);
        chk("R7 div", pll_div, 2 << d);
        rd(2, v); chk("R9 status fields", v, 16'h0300 | 16'(d * 32 + m));
        prev_mult = pll_mult;
      end
    end
    // R8 lock synchronizer
    @(negedge clk); lock_in = 1;
    @(negedge clk); chk("R8 one edge", lock_irq, 0);
    @(negedge clk); chk("R8 two edges", lock_irq, 1);
    rd(2, v); chk("R8 status lock", v[10], 1);
    @(negedge clk); lock_in = 0;
    @(negedge clk); chk("R8 fall one edge", lock_irq, 1);
    @(negedge clk); chk("R8 fall two edges", lock_irq, 0);
    finish_run();
  end
endmodule